// File: doc/BRIEF.md
# Scanline Video Address Counter with Scroll Prefetch

This block tracks the video memory address of a raster display controller across one scanline. A free-running line-cycle count, cleared at horizontal blank, is fed in each clock. At cycle 0 the block latches the line's start address and samples the fine-scroll value, the resolution select and an optional mid-line resolution switch. From these it works out the byte slot at which fetching begins and the slot at which it stops. The address then climbs in 2-byte words, one byte for every two line cycles, and a strobe marks each word fetch.

A nonzero fine-scroll value moves the fetch start a fixed number of bytes earlier, so that pixels are ready before the display area opens. A programmed resolution switch widens the line further to the left by a number of bytes that depends on where the preload window closes. The registered address is what a CPU read of the counter returns. It includes every byte of lead the line has gained.

Top module: `vid_addr_ctr`

## Requirements
- R1: While reset is held, and right after it is released, `vid_addr` reads 0 and `fetch_stb` is low.
- R2: On the clock edge that samples `line_cycle` == 0, `vid_addr` is loaded with `line_base`. All outputs appear one clock after the edge that samples the cycle they describe.
- R3: When `hscroll` is nonzero at cycle 0, the start slot moves AHEAD_BYTES (default 8) bytes earlier, which is 16 cycles. Changes to `hscroll`, `res_hi`, `sw_en`, `sw_cyc` or `line_base` after cycle 0 have no effect on the current line.
- R4: The start slot S, in bytes, is LEAD_CYC/2 (default 56/2 = 28) minus the scroll lead minus the preload extra. S saturates at 0 when that subtraction would go negative.
- R5: With h = `line_cycle`/2 and k = h − S, inside the fetch window the address is `line_base` + 2·floor(k/2). It steps by 2 on the even cycle where k becomes even and positive.
- R6: `fetch_stb` is a one-clock pulse issued with each 2-byte step, which is every 4 cycles while fetching. It never occurs outside the window.
- R7: Before the start slot (k ≤ 0), no fetch takes place and `vid_addr` holds `line_base`.
- R8: Fetching stops at byte slot LEAD_CYC/2 + LINE_BYTES (default 188). The address then holds at `line_base` + 2·floor(L/2), where L = 188 − S, until the next cycle 0.
- R9: With `sw_en` set, the preload close mark M is `sw_cyc` in high resolution (`res_hi`=1) and `sw_cyc`+12 in low resolution. The extra is (56 − M)/2, or 0 when M ≥ 56. Examples: low resolution at cycle 4 gives +20, high resolution at 44 gives +6, high resolution at 48 gives +4. With `sw_en` clear the extra is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_cycle | input | CYC_W (9) | Cycle index within the scanline, 0 at horizontal blank |
| line_base | input | ADDR_W (24) | Line start address, sampled at cycle 0 |
| hscroll | input | SCR_W (4) | Fine horizontal scroll value, sampled at cycle 0 |
| res_hi | input | 1 | Resolution of the programmed switch: 1 high, 0 low |
| sw_en | input | 1 | A resolution switch is programmed for this line |
| sw_cyc | input | CYC_W (9) | Line cycle of the programmed resolution switch |
| vid_addr | output | ADDR_W (24) | Current video address as a CPU read sees it |
| fetch_stb | output | 1 | One-clock pulse per 2-byte word fetch |

## Verification
On every cycle, the assertions check three things. The address may only stay still or rise by exactly 2 within a line. A cycle-0 sample must reload the line base. Strobes must be separated by at least three idle clocks, and the address must stay still whenever no strobe is issued. Only the bench's scenarios can show where a line starts and stops fetching: the 8-byte scroll lead, the extras from preload switches in low and high resolution, start saturation, and the fact that values changed mid-line are ignored. The bench checks these against a cycle-exact model of the address and the strobe.

// File: rtl/vac_pkg.sv
package vac_pkg;

  // Context captured at cycle 0 of a line, in byte-slot units.
  typedef struct packed {
    logic [15:0] start_slot;  // first byte slot of the fetch window
    logic [15:0] win_len;     // bytes between start slot and window end
  } vac_ctx_t;

  // Saturating subtract on 32-bit quantities.
  function automatic logic [31:0] sat_sub(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? (a - b) : 32'd0;
  endfunction

endpackage

// File: rtl/vac_rst_sync.sv
module vac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/vac_ctx.sv
module vac_ctx
  import vac_pkg::*;
#(
  parameter int CYC_W       = 9,
  parameter int SCR_W       = 4,
  parameter int LEAD_CYC    = 56,
  parameter int AHEAD_BYTES = 8,
  parameter int LINE_BYTES  = 160,
  parameter int PRE_REF     = 56,
  parameter int LO_EXT      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [SCR_W-1:0] hscroll,
  input  logic             res_hi,
  input  logic             sw_en,
  input  logic [CYC_W-1:0] sw_cyc,
  output vac_ctx_t         ctx
);
  localparam logic [31:0] LEAD_SLOT = 32'(LEAD_CYC / 2);
  localparam logic [31:0] END_SLOT  = LEAD_SLOT + 32'(LINE_BYTES);

  logic [31:0] mark;
  logic [31:0] extra;
  logic [31:0] ahead;
  logic [31:0] start_w;
  logic [31:0] len_w;
  vac_ctx_t    ctx_d;
  vac_ctx_t    ctx_q;

  always_comb begin
    mark  = {{(32-CYC_W){1'b0}}, sw_cyc};
    if (!res_hi) begin
      mark = mark + 32'(LO_EXT);
    end
    extra = sw_en ? (sat_sub(32'(PRE_REF), mark) >> 1) : 32'd0;
    ahead = (hscroll != '0) ? 32'(AHEAD_BYTES) : 32'd0;
    start_w = sat_sub(LEAD_SLOT, ahead + extra);
    len_w   = END_SLOT - start_w;
    ctx_d.start_slot = start_w[15:0];
    ctx_d.win_len    = len_w[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '0;
    end else if (line_start) begin
      ctx_q <= ctx_d;
    end
  end

  assign ctx = ctx_q;
endmodule

// File: rtl/vac_phase.sv
module vac_phase
  import vac_pkg::*;
#(
  parameter int CYC_W = 9
) (
  input  logic [CYC_W-1:0] line_cycle,
  input  vac_ctx_t         ctx,
  output logic             step
);
  logic [15:0] slot;
  logic [15:0] rel;
  logic        past_start;
  logic        in_window;
  logic        even_cyc;

  always_comb begin
    slot       = 16'(line_cycle >> 1);
    past_start = (slot > ctx.start_slot);
    rel        = slot - ctx.start_slot;
    in_window  = past_start && (rel <= ctx.win_len);
    even_cyc   = (line_cycle[0] == 1'b0) && (line_cycle != '0);
    step       = even_cyc && in_window && (rel[0] == 1'b0);
  end
endmodule

// File: rtl/vac_addr.sv
module vac_addr #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [ADDR_W-1:0] line_base,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              stb
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(2);

  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] addr_q;
  logic              stb_d;
  logic              stb_q;
  logic              addr_en;

  always_comb begin
    addr_en = line_start || step;
    addr_d  = line_start ? line_base : (addr_q + WORD_BYTES);
    stb_d   = step && !line_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
    end
  end

  assign addr = addr_q;
  assign stb  = stb_q;
endmodule

// File: rtl/vid_addr_ctr.sv
module vid_addr_ctr
  import vac_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CYC_W       = 9,
  parameter int SCR_W       = 4,
  parameter int LEAD_CYC    = 56,
  parameter int AHEAD_BYTES = 8,
  parameter int LINE_BYTES  = 160,
  parameter int PRE_REF     = 56,
  parameter int LO_EXT      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CYC_W-1:0]  line_cycle,
  input  logic [ADDR_W-1:0] line_base,
  input  logic [SCR_W-1:0]  hscroll,
  input  logic              res_hi,
  input  logic              sw_en,
  input  logic [CYC_W-1:0]  sw_cyc,
  output logic [ADDR_W-1:0] vid_addr,
  output logic              fetch_stb
);
  logic     rst_sync_n;
  logic     line_start;
  logic     step;
  vac_ctx_t ctx;

  assign line_start = (line_cycle == '0);

  vac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vac_ctx #(
    .CYC_W       (CYC_W),
    .SCR_W       (SCR_W),
    .LEAD_CYC    (LEAD_CYC),
    .AHEAD_BYTES (AHEAD_BYTES),
    .LINE_BYTES  (LINE_BYTES),
    .PRE_REF     (PRE_REF),
    .LO_EXT      (LO_EXT)
  ) u_ctx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .line_start (line_start),
    .hscroll    (hscroll),
    .res_hi     (res_hi),
    .sw_en      (sw_en),
    .sw_cyc     (sw_cyc),
    .ctx        (ctx)
  );

  vac_phase #(
    .CYC_W (CYC_W)
  ) u_phase (
    .line_cycle (line_cycle),
    .ctx        (ctx),
    .step       (step)
  );

  vac_addr #(
    .ADDR_W (ADDR_W)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .line_start (line_start),
    .line_base  (line_base),
    .step       (step),
    .addr       (vid_addr),
    .stb        (fetch_stb)
  );
endmodule

// File: rtl/vac_chk.sv
module vac_chk #(
  parameter int ADDR_W = 24,
  parameter int CYC_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CYC_W-1:0]  line_cycle,
  input logic [ADDR_W-1:0] line_base,
  input logic [ADDR_W-1:0] vid_addr,
  input logic              fetch_stb
);
  AST_RELOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cycle == '0) |=> (vid_addr == $past(line_base))); // R2

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cycle != '0) |=> ((vid_addr == $past(vid_addr)) ||
                            (vid_addr == $past(vid_addr) + ADDR_W'(2)))); // R5

  AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> (!$past(fetch_stb) && !$past(fetch_stb, 2) && !$past(fetch_stb, 3))); // R6

  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cycle != '0) |=> (fetch_stb || $stable(vid_addr))); // R7

  AST_STB_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> (vid_addr != $past(vid_addr))); // R6
endmodule

bind vid_addr_ctr vac_chk #(
  .ADDR_W (ADDR_W),
  .CYC_W  (CYC_W)
) u_vac_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .line_cycle (line_cycle),
  .line_base  (line_base),
  .vid_addr   (vid_addr),
  .fetch_stb  (fetch_stb)
);

// File: tb/tb_vid_addr_ctr.sv
`timescale 1ns/1ps
module tb_vid_addr_ctr;
  localparam int ADDR_W = 24;
  localparam int CYC_W  = 9;
  localparam int LINE_CYCLES = 512;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CYC_W-1:0]  line_cycle;
  logic [ADDR_W-1:0] line_base;
  logic [3:0]        hscroll;
  logic              res_hi;
  logic              sw_en;
  logic [CYC_W-1:0]  sw_cyc;
  logic [ADDR_W-1:0] vid_addr;
  logic              fetch_stb;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  vid_addr_ctr dut (
    .clk(clk), .rst_n(rst_n), .line_cycle(line_cycle), .line_base(line_base),
    .hscroll(hscroll), .res_hi(res_hi), .sw_en(sw_en), .sw_cyc(sw_cyc),
    .vid_addr(vid_addr), .fetch_stb(fetch_stb)
  );

  // Start slot from R3, R4, R9
  function automatic int exp_start(int scr, bit hi, bit en, int sc);
    int mark;
    int extra;
    int ahead;
    int s;
    mark  = hi ? sc : sc + 12;
    extra = (en && mark < 56) ? (56 - mark) / 2 : 0;
    ahead = (scr != 0) ? 8 : 0;
    s = 28 - ahead - extra;
    return (s < 0) ? 0 : s;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One line; scramble=1 changes inputs after cycle 0 (R3 ignore)
  task automatic run_line(string tag, int base, int scr, bit hi, bit en, int sc, bit scramble);
    int s;
    int len;
    s   = exp_start(scr, hi, en, sc);
    len = 188 - s;
    for (int c = 0; c < LINE_CYCLES; c++) begin
      int k;
      int eff;
      bit stb_e;
      longint a_e;
      line_cycle = CYC_W'(c);
      if (c == 0 || !scramble) begin
        line_base = ADDR_W'(base);
        hscroll   = 4'(scr);
        res_hi    = hi;
        sw_en     = en;
        sw_cyc    = CYC_W'(sc);
      end else begin
        line_base = ADDR_W'($urandom);
        hscroll   = 4'($urandom);
        res_hi    = 1'($urandom);
        sw_en     = 1'($urandom);
        sw_cyc    = CYC_W'($urandom_range(0, 60));
      end
      @(posedge clk);
      #1;
      k   = (c >> 1) - s;
      eff = (k < 0) ? 0 : ((k > len) ? len : k);
      a_e = (longint'(base) + (eff & ~1)) & 64'hFF_FFFF;
      stb_e = (c != 0) && (c % 2 == 0) && (k > 0) && (k % 2 == 0) && (k <= len);
      if (c == 0)       check({tag, "/R2 reload"}, vid_addr, a_e);
      else if (k <= 0)  check({tag, "/R7 preload hold"}, vid_addr, a_e);
      else if (k > len) check({tag, "/R8 end hold"}, vid_addr, a_e);
      else              check({tag, "/R5 advance"}, vid_addr, a_e);
      check({tag, "/R6 strobe"}, fetch_stb, stb_e);
      // Fetch start slot check: first strobe lands at k == 2
      if (k == 2 && c % 2 == 0 && c != 0 && len >= 2)
        check({tag, "/R4 start slot"}, fetch_stb, 1);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    line_cycle = CYC_W'(5);
    line_base = 24'h123456;
    hscroll = 4'd3;
    res_hi = 1'b0;
    sw_en = 1'b0;
    sw_cyc = '0;
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset addr", vid_addr, 0);
    check("R1 reset stb", fetch_stb, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 after release addr", vid_addr, 0);
    check("R1 after release stb", fetch_stb, 0);

    run_line("R5 plain",            24'h010000, 0, 0, 0, 0,  0);
    run_line("R3 scroll lead",      24'h020000, 5, 0, 0, 0,  0);
    run_line("R9 low sw4 (+20)",    24'h030000, 0, 0, 1, 4,  0);
    run_line("R9 high sw44 (+6)",   24'h040000, 0, 1, 1, 44, 0);
    run_line("R9 high sw48 (+4)",   24'h050000, 0, 1, 1, 48, 0);
    run_line("R9 late sw no extra", 24'h060000, 0, 1, 1, 60, 0);
    run_line("R4 saturate",         24'h070000, 9, 0, 1, 0,  0);
    run_line("R8 addr wrap",        24'hFFFFC0, 1, 1, 0, 0,  0);
    run_line("R3 midline ignored",  24'h080000, 0, 1, 0, 0,  1);
    for (int i = 0; i < 28; i++) begin
      run_line("rand", int'($urandom & 32'hFFFFFE), int'($urandom_range(0, 15)),
               1'($urandom), 1'($urandom), int'($urandom_range(0, 70)), 1'($urandom));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule